// File: doc/BRIEF.md
# Configurable UART Transmitter with Holding Register

This block frames characters and shifts them out on a serial line that rests high. A one-entry holding register sits in front of the shift register. Software can therefore queue the next character while the current one is still going out. Each frame has one low start bit, then 5 to 9 data bits in either bit order, then an optional parity bit, then one, one-and-a-half or two high stop bits. Bit timing comes from an external tick at sixteen times the baud rate, and a bit lasts `OVS` ticks. The data length, parity, stop count and bit order are sampled when a character moves from the holding register into the shift register.

Four single-cycle command strobes control the block: enable, disable, soft reset and start-break. Two status flags, ready and empty, each drive an interrupt request through a mask bit.

The control state machine has three states:
- OFF to ON on enable.
- ON to DRAIN on disable.
- DRAIN back to ON on enable.
- DRAIN to OFF once both the holding register and the shift register are empty.
- Any state to OFF on soft reset.

The frame state machine runs IDLE, then START, then DATA, then an optional PARITY, then STOP:
- IDLE to START on a load from the holding register.
- START to DATA after one bit time.
- DATA to PARITY or to STOP after the last data bit.
- PARITY to STOP after one bit time.
- STOP to IDLE after the stop time.
- Any state to IDLE on soft reset.

Top module: `serial_tx`

## Requirements
- R1: After `rst_n` the transmitter is off: `rdy`=0, `empty`=0, `txd`=1. An `cmd_en` pulse raises `rdy` and `empty` on the next cycle.
- R2: A frame is one low start bit, then the data bits, then the parity bit if enabled, then high stop bits. Each bit lasts `OVS` ticks of `tick16`, and `txd` stays high while no frame is in progress.
- R3: `cfg_len` = 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. `cfg_nine`=1 forces 9 data bits whatever `cfg_len` holds. Data bits above the length are not sent.
- R4: `cfg_msb`=0 sends the data LSB first; `cfg_msb`=1 sends it MSB first, the MSB being bit length-1.
- R5: `cfg_par` selects the parity bit after the data:
  - 0: even, so the parity bit makes the count of ones among data and parity even.
  - 1: odd.
  - 2: always 0.
  - 3: always 1.
  - 4 to 7: no parity bit.
- R6: `cfg_stop` selects the stop time:
  - 0: one bit.
  - 1: one and a half bits (`OVS`*3/2 ticks) when `cfg_async`=1, and one bit when `cfg_async`=0.
  - 2 or 3: two bits.
- R7: `rdy` is high when the block is on and the holding register is empty. `empty` is high only when, in addition, the shift register is idle. A queued character starts right after the current frame ends.
- R8: A write (`wr_valid`) while `rdy`=0 has no effect: the character is never sent.
- R9: `cmd_dis` clears `rdy` and `empty` on the next cycle. The character in the shift register and the one in the holding register are both sent in full before the block turns off. After that, writes are dropped until `cmd_en`.
- R10: `cmd_rst` stops the frame at once (`txd`=1 on the next cycle), empties the holding register, clears both flags and turns the block off. After `cmd_en`, new frames are sent with the unchanged configuration.
- R11: `cmd_brk` clears `rdy` and `empty` on the next cycle. They stay low, and writes are dropped, until `cmd_en` or `cmd_rst`.
- R12: `irq_rdy` follows `rdy` when `irq_mask[0]`=1 and is 0 otherwise. `irq_empty` follows `empty` when `irq_mask[1]`=1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, one cycle wide, `OVS` per bit |
| cmd_en | input | 1 | Enable strobe |
| cmd_dis | input | 1 | Graceful disable strobe |
| cmd_rst | input | 1 | Soft reset strobe |
| cmd_brk | input | 1 | Start-break strobe, clears status |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_nine | input | 1 | Nine-bit override |
| cfg_par | input | 3 | Parity mode |
| cfg_stop | input | 2 | Stop time code |
| cfg_msb | input | 1 | MSB-first order |
| cfg_async | input | 1 | Asynchronous mode, allows 1.5 stop bits |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | 9 | Character to send |
| irq_mask | input | 2 | Interrupt mask: bit 0 ready, bit 1 empty |
| txd | output | 1 | Serial line |
| rdy | output | 1 | Holding register free |
| empty | output | 1 | Holding and shift registers both empty |
| irq_rdy | output | 1 | Masked ready request |
| irq_empty | output | 1 | Masked empty request |

## Verification
The bench builds the block with the default `OVS`=16 and drives a tick every fourth clock, so one bit lasts 64 clocks. At that rate every frame is sampled at the middle of each bit. The start-to-start spacing of back-to-back frames separates the 16, 24 and 32 tick stop times, with margin for the tick phase. The 16-tick bit also makes the 1.5-bit stop an integral 24 ticks, so that case is reachable and can be told apart from one bit in synchronous mode.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int MAXB = 9;

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PARITY, S_STOP} frm_state_e;
    typedef enum logic [1:0] {C_OFF, C_ON, C_DRAIN} ctl_state_e;

    localparam logic [2:0] PAR_EVEN  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_SPACE = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;

    function automatic logic [3:0] data_len(input logic [1:0] len, input logic nine);
        return nine ? 4'd9 : 4'd5 + {2'b00, len};
    endfunction

    function automatic logic calc_par(input logic [MAXB-1:0] d, input logic [3:0] n,
                                      input logic [2:0] mode);
        logic [MAXB-1:0] msk;
        logic ones;
        msk  = 9'h1FF >> (4'd9 - n);
        ones = ^(d & msk);
        unique case (mode)
            PAR_EVEN:  return ones;
            PAR_ODD:   return ~ones;
            PAR_MARK:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
    import serial_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_en,
    input  logic            cmd_dis,
    input  logic            cmd_rst,
    input  logic            cmd_brk,
    input  logic            wr_valid,
    input  logic [MAXB-1:0] wr_data,
    input  logic            shift_busy,
    output logic [MAXB-1:0] hold_data,
    output logic            load,
    output logic            rdy,
    output logic            empty
);

    ctl_state_e cst, cst_nx;
    logic       hold_v;
    logic       brk_blk;
    logic       accept;

    // Next control state
    always_comb begin
        cst_nx = cst;
        unique case (cst)
            C_OFF:   if (cmd_en && !cmd_dis) cst_nx = C_ON;
            C_ON:    if (cmd_dis) cst_nx = C_DRAIN;
            C_DRAIN: begin
                if (cmd_en && !cmd_dis)        cst_nx = C_ON;
                else if (!hold_v && !shift_busy) cst_nx = C_OFF;
            end
            default: cst_nx = C_OFF;
        endcase
        if (cmd_rst) cst_nx = C_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cst <= C_OFF;
        else        cst <= cst_nx;
    end

    // Outputs
    always_comb begin
        rdy    = (cst == C_ON) && !brk_blk && !hold_v;
        empty  = rdy && !shift_busy;
        load   = (cst != C_OFF) && hold_v && !shift_busy;
        accept = wr_valid && rdy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_data <= '0;
            brk_blk   <= 1'b0;
        end else begin
            if (cmd_rst)      hold_v <= 1'b0;
            else if (accept)  hold_v <= 1'b1;
            else if (load)    hold_v <= 1'b0;
            if (accept) hold_data <= wr_data;
            if (cmd_rst)      brk_blk <= 1'b0;
            else if (cmd_brk) brk_blk <= 1'b1;
            else if (cmd_en)  brk_blk <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift
    import serial_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst,
    input  logic            tick,
    input  logic            load,
    input  logic [MAXB-1:0] ld_data,
    input  logic [1:0]      cfg_len,
    input  logic            cfg_nine,
    input  logic [2:0]      cfg_par,
    input  logic [1:0]      cfg_stop,
    input  logic            cfg_msb,
    input  logic            cfg_async,
    output logic            txd,
    output logic            busy
);

    localparam int CW = $clog2(2*OVS + 1);
    localparam int IW = $clog2(MAXB + 1);

    frm_state_e      st, st_nx;
    logic [CW-1:0]   cnt, lim, stop_lim;
    logic [IW-1:0]   idx, nb, sel;
    logic [MAXB-1:0] sh;
    logic            pen, pbit, msb, bit_end;

    always_comb begin
        lim     = (st == S_STOP) ? stop_lim : CW'(OVS);
        bit_end = tick && (cnt == lim - CW'(1));
        sel     = msb ? (nb - IW'(1) - idx) : idx;
    end

    // Next frame state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (load) st_nx = S_START;
            S_START:  if (bit_end) st_nx = S_DATA;
            S_DATA:   if (bit_end && idx == nb - IW'(1)) st_nx = pen ? S_PARITY : S_STOP;
            S_PARITY: if (bit_end) st_nx = S_STOP;
            S_STOP:   if (bit_end) st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st <= S_IDLE;
        else if (srst) st <= S_IDLE;
        else           st <= st_nx;
    end

    // Tick counter, bit index and captured frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            idx      <= '0;
            sh       <= '0;
            nb       <= IW'(8);
            pen      <= 1'b0;
            pbit     <= 1'b0;
            msb      <= 1'b0;
            stop_lim <= CW'(OVS);
        end else begin
            if (load || bit_end || srst)  cnt <= '0;
            else if (tick && st != S_IDLE) cnt <= cnt + CW'(1);
            if (st == S_START)               idx <= '0;
            else if (st == S_DATA && bit_end) idx <= idx + IW'(1);
            if (load) begin
                sh   <= ld_data;
                nb   <= IW'(data_len(cfg_len, cfg_nine));
                pen  <= !cfg_par[2];
                pbit <= calc_par(ld_data, data_len(cfg_len, cfg_nine), cfg_par);
                msb  <= cfg_msb;
                unique case (cfg_stop)
                    2'd0:    stop_lim <= CW'(OVS);
                    2'd1:    stop_lim <= cfg_async ? CW'(OVS + OVS/2) : CW'(OVS);
                    default: stop_lim <= CW'(2*OVS);
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (st != S_IDLE);
        unique case (st)
            S_START:  txd = 1'b0;
            S_DATA:   txd = sh[sel];
            S_PARITY: txd = pbit;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import serial_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick16,
    input  logic            cmd_en,
    input  logic            cmd_dis,
    input  logic            cmd_rst,
    input  logic            cmd_brk,
    input  logic [1:0]      cfg_len,
    input  logic            cfg_nine,
    input  logic [2:0]      cfg_par,
    input  logic [1:0]      cfg_stop,
    input  logic            cfg_msb,
    input  logic            cfg_async,
    input  logic            wr_valid,
    input  logic [MAXB-1:0] wr_data,
    input  logic [1:0]      irq_mask,
    output logic            txd,
    output logic            rdy,
    output logic            empty,
    output logic            irq_rdy,
    output logic            irq_empty
);

    logic [MAXB-1:0] hold_data;
    logic            load, busy;

    serial_tx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_rst(cmd_rst), .cmd_brk(cmd_brk),
        .wr_valid(wr_valid), .wr_data(wr_data), .shift_busy(busy),
        .hold_data(hold_data), .load(load), .rdy(rdy), .empty(empty)
    );

    serial_tx_shift #(.OVS(OVS)) u_shift (
        .clk(clk), .rst_n(rst_n), .srst(cmd_rst), .tick(tick16), .load(load),
        .ld_data(hold_data), .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_par(cfg_par),
        .cfg_stop(cfg_stop), .cfg_msb(cfg_msb), .cfg_async(cfg_async),
        .txd(txd), .busy(busy)
    );

    assign irq_rdy   = rdy && irq_mask[0];
    assign irq_empty = empty && irq_mask[1];

endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_en,
    input logic       cmd_dis,
    input logic       cmd_rst,
    input logic       cmd_brk,
    input logic [1:0] irq_mask,
    input logic       txd,
    input logic       rdy,
    input logic       empty,
    input logic       irq_rdy,
    input logic       irq_empty
);

    a_r7_empty_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> rdy);

    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> txd);

    a_r10_soft_reset_halts: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (txd && !rdy && !empty));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_dis && !cmd_rst) |=> (!rdy && !empty));

    a_r11_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_brk |=> (!rdy && !empty));

    a_r12_irq_rdy_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rdy |-> (irq_mask[0] && rdy));

    a_r12_irq_empty_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> (irq_mask[1] && empty));

endmodule

bind serial_tx serial_tx_chk u_chk (.*);

// File: tb/serial_tx_test.sv
`timescale 1ns/1ps
module serial_tx_test;

    localparam int BITCLK = 64;   // 16 ticks x 4 clocks

    logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
    logic cmd_en = 0, cmd_dis = 0, cmd_rst = 0, cmd_brk = 0;
    logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0, irq_mask = 2'b00;
    logic cfg_nine = 0, cfg_msb = 0, cfg_async = 1;
    logic [2:0] cfg_par = 3'd4;
    logic wr_valid = 0;
    logic [8:0] wr_data = '0;
    logic txd, rdy, empty, irq_rdy, irq_empty;

    int nchk = 0, nfail = 0;
    longint cyc = 0;
    logic [1:0] tdiv = '0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    serial_tx uut (.*);

    // {len[15:14], nine[13], par[12:10], msb[9], data[8:0]}
    localparam logic [15:0] VEC [8] = '{
        {2'd3, 1'b0, 3'd4, 1'b0, 9'h0A5},
        {2'd3, 1'b0, 3'd0, 1'b0, 9'h037},
        {2'd3, 1'b0, 3'd1, 1'b1, 9'h037},
        {2'd0, 1'b0, 3'd2, 1'b0, 9'h1F3},
        {2'd1, 1'b0, 3'd3, 1'b1, 9'h02D},
        {2'd2, 1'b0, 3'd1, 1'b0, 9'h000},
        {2'd0, 1'b1, 3'd0, 1'b0, 9'h1A5},
        {2'd3, 1'b1, 3'd4, 1'b1, 9'h155}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [1:0] len, input logic nine,
            input logic [2:0] par, input logic msb, input logic [8:0] d, output int total);
        logic [11:0] b = '0;
        int n = nine ? 9 : 5 + int'(len);
        int ones = 0;
        for (int i = 0; i < n; i++) begin
            b[1+i] = msb ? d[n-1-i] : d[i];
            ones += int'(d[i]);
        end
        total = n + 2;
        if (par < 3'd4) begin
            case (par)
                3'd0: b[1+n] = logic'(ones % 2);
                3'd1: b[1+n] = logic'(1 - ones % 2);
                3'd2: b[1+n] = 1'b0;
                default: b[1+n] = 1'b1;
            endcase
            total++;
        end
        b[total-1] = 1'b1;
        return b;
    endfunction

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: cmd_en = 1;  1: cmd_dis = 1;  2: cmd_rst = 1;  default: cmd_brk = 1;
        endcase
        @(negedge clk);
        cmd_en = 0; cmd_dis = 0; cmd_rst = 0; cmd_brk = 0;
    endtask

    task automatic send(input logic [8:0] d);
        @(negedge clk);
        while (!rdy) @(negedge clk);
        wr_data = d; wr_valid = 1;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic force_write(input logic [8:0] d);
        @(negedge clk);
        wr_data = d; wr_valid = 1;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic grab(input int nbits, output logic [11:0] bits, output longint t0);
        bits = '0;
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        t0 = cyc;
        repeat (BITCLK/2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < nbits; i++) begin
            repeat (BITCLK) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic quiet(input int ncyc, output bit stayed_high);
        stayed_high = 1;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed_high = 0;
        end
    endtask

    initial begin : watchdog
        while (cyc < 150000 && !done) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] got, ex;
        longint t0, t1;
        int tot, d2;
        bit q;

        repeat (3) @(negedge clk);
        chk(!rdy && !empty && txd, "R1", "flags/line after reset", {rdy, empty, txd}, 3'b001);
        rst_n = 1;
        pulse(0);
        chk(rdy && empty, "R1", "flags after enable", {rdy, empty}, 2'b11);

        // Vector table: R2 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            cfg_len = VEC[v][15:14]; cfg_nine = VEC[v][13];
            cfg_par = VEC[v][12:10]; cfg_msb = VEC[v][9];
            ex = exp_frame(cfg_len, cfg_nine, cfg_par, cfg_msb, VEC[v][8:0], tot);
            send(VEC[v][8:0]);
            grab(tot, got, t0);
            chk(got == ex, "R2/R3/R4/R5", $sformatf("frame vector %0d", v), got, ex);
            repeat (BITCLK) @(negedge clk);
        end

        // R6 stop lengths via start-to-start spacing, 8 bits no parity
        cfg_len = 2'd3; cfg_nine = 0; cfg_par = 3'd4; cfg_msb = 0;
        for (int s = 0; s < 4; s++) begin
            int st_ticks;
            cfg_stop  = (s == 3) ? 2'd2 : ((s == 0) ? 2'd0 : 2'd1);
            cfg_async = (s != 2);
            st_ticks  = (s == 0 || s == 2) ? 16 : ((s == 1) ? 24 : 32);
            send(9'h055); send(9'h0AA);
            grab(10, got, t0);
            grab(10, got, t1);
            d2 = int'(t1 - t0);
            chk(d2 >= 4*(144+st_ticks) - 4 && d2 <= 4*(144+st_ticks) + 2, "R6",
                $sformatf("start spacing, stop case %0d", s), d2, 4*(144+st_ticks) - 1);
            repeat (BITCLK*3) @(negedge clk);
        end
        cfg_stop = 2'd0; cfg_async = 1;

        // R7 R8: queued character follows; write while not ready dropped
        send(9'h011);
        chk(!empty, "R7", "empty low while shifting", empty, 0);
        send(9'h022);
        chk(!rdy && !empty, "R7", "ready low with holding full", {rdy, empty}, 2'b00);
        force_write(9'h0FF);
        grab(10, got, t0);
        ex = exp_frame(2'd3, 0, 3'd4, 0, 9'h011, tot);
        chk(got == ex, "R7", "first queued frame", got, ex);
        grab(10, got, t0);
        ex = exp_frame(2'd3, 0, 3'd4, 0, 9'h022, tot);
        chk(got == ex, "R7", "second queued frame", got, ex);
        quiet(BITCLK*14, q);
        chk(q, "R8", "dropped write produced no frame", q, 1);
        chk(rdy && empty, "R7", "flags after drain", {rdy, empty}, 2'b11);

        // R9 graceful disable
        send(9'h0C3); send(9'h03C);
        pulse(1);
        chk(!rdy && !empty, "R9", "flags after disable", {rdy, empty}, 2'b00);
        grab(10, got, t0);
        ex = exp_frame(2'd3, 0, 3'd4, 0, 9'h0C3, tot);
        chk(got == ex, "R9", "shifting frame completed", got, ex);
        grab(10, got, t0);
        ex = exp_frame(2'd3, 0, 3'd4, 0, 9'h03C, tot);
        chk(got == ex, "R9", "held frame completed", got, ex);
        repeat (100) @(negedge clk);
        force_write(9'h0F0);
        quiet(BITCLK*14, q);
        chk(q && !rdy && !empty, "R9", "off after drain, write dropped", {q, rdy, empty}, 3'b100);
        pulse(0);
        chk(rdy && empty, "R9", "re-enable flags", {rdy, empty}, 2'b11);

        // R10 soft reset mid-frame
        send(9'h000);
        repeat (200) @(negedge clk);
        chk(txd == 1'b0, "R10", "line low mid-frame before reset", txd, 0);
        pulse(2);
        chk(txd && !rdy && !empty, "R10", "halt after soft reset", {txd, rdy, empty}, 3'b100);
        quiet(BITCLK*12, q);
        chk(q, "R10", "line stays idle after soft reset", q, 1);
        pulse(0);
        cfg_par = 3'd0;
        send(9'h0B7);
        grab(11, got, t0);
        ex = exp_frame(2'd3, 0, 3'd0, 0, 9'h0B7, tot);
        chk(got == ex, "R10", "frame after re-enable", got, ex);
        cfg_par = 3'd4;
        repeat (BITCLK*2) @(negedge clk);

        // R11 start-break clears status
        pulse(3);
        chk(!rdy && !empty, "R11", "flags after break", {rdy, empty}, 2'b00);
        force_write(9'h081);
        quiet(BITCLK*12, q);
        chk(q && !rdy, "R11", "write dropped while blocked", {q, rdy}, 2'b10);
        pulse(0);
        chk(rdy && empty, "R11", "flags after enable", {rdy, empty}, 2'b11);

        // R12 interrupt masking
        irq_mask = 2'b11;
        send(9'h066);
        repeat (2) @(negedge clk);
        chk(irq_rdy && !irq_empty, "R12", "busy, mask 11", {irq_rdy, irq_empty}, 2'b10);
        irq_mask = 2'b00; #1;
        chk(!irq_rdy && !irq_empty, "R12", "busy, mask 00", {irq_rdy, irq_empty}, 2'b00);
        grab(10, got, t0);
        repeat (100) @(negedge clk);
        irq_mask = 2'b10; #1;
        chk(!irq_rdy && irq_empty, "R12", "idle, mask 10", {irq_rdy, irq_empty}, 2'b01);
        irq_mask = 2'b01; #1;
        chk(irq_rdy && !irq_empty, "R12", "idle, mask 01", {irq_rdy, irq_empty}, 2'b10);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule